// File: doc/BRIEF.md
# Reduced RV32I Instruction Decoder

This block turns one 32-bit instruction word into the fields and control signals an execution stage needs. It accepts a fixed set of 33 base-integer instructions: register-register arithmetic, register-immediate arithmetic, loads, stores, load-upper-immediate, conditional branches and the two jumps. From each word it produces the three register indices, a compact operation number, a 32-bit sign-extended immediate and a small set of control flags.

The block has no state and no clock. Its outputs depend only on the current word. Any word outside the accepted set raises a not-implemented flag and forces every control flag low. The surrounding pipeline can then trap without first decoding the word again. Immediates are reassembled from their format-specific bit positions, including the scattered branch and jump layouts. The choice of format depends on the 7-bit major opcode alone.

Top module: `rvd_decoder`

## Requirements
- R1: `rd_o` = instr[11:7], `rs1_o` = instr[19:15] and `rs2_o` = instr[24:20] for every word, valid or not.
- R2: For an accepted word, `op_o` carries the following numbers. Register ops use major opcode 0110011 (func3/func7): add 1 (000/0000000), sub 2 (000/0100000), xor 3 (100), or 4 (110), and 5 (111), sll 6 (001), srl 7 (101/0000000), sra 8 (101/0100000), slt 9 (010), sltu 10 (011). Immediate ops use 0010011 (func3): addi 11 (000), xori 12 (100), ori 13 (110), andi 14 (111), slti 15 (010), sltiu 16 (011). Loads use 0000011: lb 17 (000), lh 18 (001), lw 19 (010), lbu 20 (100), lhu 21 (101). Stores use 0100011: sb 22 (000), sh 23 (001), sw 24 (010). lui is 25 (0110111). Branches use 1100011: beq 26 (000), bne 27 (001), blt 28 (100), bge 29 (101), bltu 30 (110), bgeu 31 (111). jal is 32 (1101111) and jalr is 33 (1100111, func3 000).
- R3: Every other word raises `not_impl_o` and gives `op_o` = 0. This includes 0xFFFFFFFF, a register op whose func7 is neither 0000000 nor, where allowed, 0100000, and a jalr with func3 other than 000.
- R4: For major opcodes 0010011, 0000011 and 1100111, `imm_o` is instr[31:20] sign-extended from bit 11. For 0100011 it is {instr[31:25], instr[11:7]} sign-extended from bit 11. For 0110111 it is instr[31:12] followed by twelve zeros.
- R5: For 1100011, `imm_o` bit 12 = instr[31], bit 11 = instr[7], bits 10:5 = instr[30:25], bits 4:1 = instr[11:8] and bit 0 = 0, sign-extended from bit 12.
- R6: For 1101111, `imm_o` bit 20 = instr[31], bits 19:12 = instr[19:12], bit 11 = instr[20], bits 10:1 = instr[30:21] and bit 0 = 0, sign-extended from bit 20.
- R7: `imm_o` depends only on the major opcode. It is 0 for 0110011 and for any unlisted major opcode, and an accepted major opcode with a rejected func field still yields that opcode's immediate.
- R8: `mem_rd_o` is 1 for loads only and `mem_wr_o` is 1 for stores only. For both, `mem_size_o` = func3[1:0] (0 byte, 1 half, 2 word), otherwise 0. `load_unsigned_o` = func3[2] for loads, otherwise 0.
- R9: `branch_o` is 1 for operations 26 to 31 and `jump_o` is 1 for operations 32 and 33. Both are 0 for everything else.
- R10: `reg_wr_o` is 1 for operations 1 to 21, 25, 32 and 33 when `rd_o` is not 0. It is 0 when `rd_o` is 0 and for stores and branches.
- R11: While `not_impl_o` is 1, `reg_wr_o`, `mem_rd_o`, `mem_wr_o`, `mem_size_o`, `load_unsigned_o`, `branch_o` and `jump_o` are all 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| instr_i | input | 32 | Instruction word to decode |
| rd_o | output | 5 | Destination register index |
| rs1_o | output | 5 | First source register index |
| rs2_o | output | 5 | Second source register index |
| op_o | output | 6 | Operation number (0 = none) |
| imm_o | output | 32 | Reassembled sign-extended immediate |
| reg_wr_o | output | 1 | Result is written to rd |
| mem_rd_o | output | 1 | Operation is a load |
| mem_wr_o | output | 1 | Operation is a store |
| mem_size_o | output | 2 | Access width: 0 byte, 1 half, 2 word |
| load_unsigned_o | output | 1 | Load zero-extends |
| branch_o | output | 1 | Conditional branch |
| jump_o | output | 1 | Unconditional jump |
| not_impl_o | output | 1 | Word is outside the accepted set |

## Verification
The checker tests output-level invariants on every evaluation. A rejected word must leave every control flag low and the operation number at zero. rd 0 must never be written, and a load and a store must never be flagged together. Branch and jump offsets must stay even, the low twelve bits of an upper immediate must be zero, and memory size must be zero whenever no access is flagged. Whether each word maps to the correct operation number, and whether the scattered immediate bits land in the correct positions, can only be shown by the bench. Its sweep covers every major opcode against every func3 and several func7 values, and a pseudo-random pass supplies varied immediate bits.

// File: rtl/rvd_pkg.sv
// Shared constants and types for the reduced instruction decoder.
// Assumes a 32-bit instruction word with the standard field layout.
package rvd_pkg;
    localparam int ILEN   = 32;
    localparam int RIDX_W = 5;
    localparam int OPC_W  = 7;
    localparam int F3_W   = 3;
    localparam int F7_W   = 7;
    localparam int OP_W   = 6;
    localparam int SIZE_W = 2;

    localparam logic [OPC_W-1:0] OPC_REG    = 7'b0110011;
    localparam logic [OPC_W-1:0] OPC_IMM    = 7'b0010011;
    localparam logic [OPC_W-1:0] OPC_LOAD   = 7'b0000011;
    localparam logic [OPC_W-1:0] OPC_STORE  = 7'b0100011;
    localparam logic [OPC_W-1:0] OPC_LUI    = 7'b0110111;
    localparam logic [OPC_W-1:0] OPC_BRANCH = 7'b1100011;
    localparam logic [OPC_W-1:0] OPC_JAL    = 7'b1101111;
    localparam logic [OPC_W-1:0] OPC_JALR   = 7'b1100111;

    localparam logic [F7_W-1:0] F7_BASE = 7'b0000000;
    localparam logic [F7_W-1:0] F7_ALT  = 7'b0100000;

    typedef enum logic [OP_W-1:0] {
        OP_NONE = 6'd0,
        OP_ADD = 6'd1, OP_SUB = 6'd2, OP_XOR = 6'd3, OP_OR = 6'd4, OP_AND = 6'd5,
        OP_SLL = 6'd6, OP_SRL = 6'd7, OP_SRA = 6'd8, OP_SLT = 6'd9, OP_SLTU = 6'd10,
        OP_ADDI = 6'd11, OP_XORI = 6'd12, OP_ORI = 6'd13, OP_ANDI = 6'd14,
        OP_SLTI = 6'd15, OP_SLTIU = 6'd16,
        OP_LB = 6'd17, OP_LH = 6'd18, OP_LW = 6'd19, OP_LBU = 6'd20, OP_LHU = 6'd21,
        OP_SB = 6'd22, OP_SH = 6'd23, OP_SW = 6'd24,
        OP_LUI = 6'd25,
        OP_BEQ = 6'd26, OP_BNE = 6'd27, OP_BLT = 6'd28, OP_BGE = 6'd29,
        OP_BLTU = 6'd30, OP_BGEU = 6'd31,
        OP_JAL = 6'd32, OP_JALR = 6'd33
    } op_e;

    typedef enum logic [2:0] {
        FMT_NONE, FMT_R, FMT_I, FMT_S, FMT_B, FMT_U, FMT_J
    } fmt_e;

    typedef struct packed {
        logic              wr_rd;
        logic              mem_rd;
        logic              mem_wr;
        logic [SIZE_W-1:0] size;
        logic              uns;
        logic              branch;
        logic              jump;
    } ctl_t;
endpackage

// File: rtl/rvd_field_split.sv
// Slices the instruction word into its fixed-position fields.
// Assumes the standard layout; no decoding happens here.
module rvd_field_split
    import rvd_pkg::*;
#(
    parameter int W = ILEN
) (
    input  logic [W-1:0]      instr,
    output logic [OPC_W-1:0]  opcode,
    output logic [RIDX_W-1:0] rd,
    output logic [F3_W-1:0]   f3,
    output logic [RIDX_W-1:0] rs1,
    output logic [RIDX_W-1:0] rs2,
    output logic [F7_W-1:0]   f7
);
    localparam int RD_LO  = OPC_W;
    localparam int F3_LO  = RD_LO + RIDX_W;
    localparam int RS1_LO = F3_LO + F3_W;
    localparam int RS2_LO = RS1_LO + RIDX_W;
    localparam int F7_LO  = RS2_LO + RIDX_W;

    // Purpose: fixed bit slices of the word.
    always_comb begin
        opcode = instr[OPC_W-1:0];
        rd     = instr[RD_LO +: RIDX_W];
        f3     = instr[F3_LO +: F3_W];
        rs1    = instr[RS1_LO +: RIDX_W];
        rs2    = instr[RS2_LO +: RIDX_W];
        f7     = instr[F7_LO +: F7_W];
    end
endmodule

// File: rtl/rvd_imm_gen.sv
// Reassembles the immediate of the format chosen by the major opcode.
// Assumes a 32-bit word; formats that carry no immediate return zero.
module rvd_imm_gen
    import rvd_pkg::*;
#(
    parameter int W = ILEN
) (
    input  logic [W-1:0] instr,
    input  fmt_e         fmt,
    output logic [W-1:0] imm
);
    localparam int MSB = W - 1;

    logic [W-1:0] imm_i, imm_s, imm_b, imm_u, imm_j;

    // Purpose: build every candidate immediate in parallel.
    always_comb begin
        imm_i = {{(W-12){instr[MSB]}}, instr[31:20]};
        imm_s = {{(W-12){instr[MSB]}}, instr[31:25], instr[11:7]};
        imm_b = {{(W-13){instr[MSB]}}, instr[31], instr[7], instr[30:25],
                 instr[11:8], 1'b0};
        imm_u = {instr[31:12], 12'b0};
        imm_j = {{(W-21){instr[MSB]}}, instr[31], instr[19:12], instr[20],
                 instr[30:21], 1'b0};
    end

    // Purpose: select the candidate that belongs to the format.
    always_comb begin
        case (fmt)
            FMT_I:   imm = imm_i;
            FMT_S:   imm = imm_s;
            FMT_B:   imm = imm_b;
            FMT_U:   imm = imm_u;
            FMT_J:   imm = imm_j;
            default: imm = '0;
        endcase
    end
endmodule

// File: rtl/rvd_op_lookup.sv
// Maps opcode/func3/func7 to an operation number, format and control set.
// Assumes rd is the raw destination field; rejected words clear all controls.
module rvd_op_lookup
    import rvd_pkg::*;
(
    input  logic [OPC_W-1:0]  opcode,
    input  logic [F3_W-1:0]   f3,
    input  logic [F7_W-1:0]   f7,
    input  logic [RIDX_W-1:0] rd,
    output op_e               op,
    output fmt_e              fmt,
    output ctl_t              ctl,
    output logic              not_impl
);
    logic f7_base, f7_alt;
    logic cls_wr, cls_ld, cls_st, cls_br, cls_jp;

    // Purpose: recognise the two permitted func7 values.
    always_comb begin
        f7_base = (f7 == F7_BASE);
        f7_alt  = (f7 == F7_ALT);
    end

    // Purpose: major-opcode and func decode into an operation and class.
    always_comb begin
        op = OP_NONE;
        fmt = FMT_NONE;
        cls_wr = 1'b0; cls_ld = 1'b0; cls_st = 1'b0; cls_br = 1'b0; cls_jp = 1'b0;
        case (opcode)
            OPC_REG: begin
                fmt = FMT_R; cls_wr = 1'b1;
                case (f3)
                    3'b000: op = f7_base ? OP_ADD : (f7_alt ? OP_SUB : OP_NONE);
                    3'b001: op = f7_base ? OP_SLL : OP_NONE;
                    3'b010: op = f7_base ? OP_SLT : OP_NONE;
                    3'b011: op = f7_base ? OP_SLTU : OP_NONE;
                    3'b100: op = f7_base ? OP_XOR : OP_NONE;
                    3'b101: op = f7_base ? OP_SRL : (f7_alt ? OP_SRA : OP_NONE);
                    3'b110: op = f7_base ? OP_OR : OP_NONE;
                    default: op = f7_base ? OP_AND : OP_NONE;
                endcase
            end
            OPC_IMM: begin
                fmt = FMT_I; cls_wr = 1'b1;
                case (f3)
                    3'b000: op = OP_ADDI;
                    3'b010: op = OP_SLTI;
                    3'b011: op = OP_SLTIU;
                    3'b100: op = OP_XORI;
                    3'b110: op = OP_ORI;
                    3'b111: op = OP_ANDI;
                    default: op = OP_NONE;
                endcase
            end
            OPC_LOAD: begin
                fmt = FMT_I; cls_wr = 1'b1; cls_ld = 1'b1;
                case (f3)
                    3'b000: op = OP_LB;
                    3'b001: op = OP_LH;
                    3'b010: op = OP_LW;
                    3'b100: op = OP_LBU;
                    3'b101: op = OP_LHU;
                    default: op = OP_NONE;
                endcase
            end
            OPC_STORE: begin
                fmt = FMT_S; cls_st = 1'b1;
                case (f3)
                    3'b000: op = OP_SB;
                    3'b001: op = OP_SH;
                    3'b010: op = OP_SW;
                    default: op = OP_NONE;
                endcase
            end
            OPC_LUI: begin
                fmt = FMT_U; cls_wr = 1'b1; op = OP_LUI;
            end
            OPC_BRANCH: begin
                fmt = FMT_B; cls_br = 1'b1;
                case (f3)
                    3'b000: op = OP_BEQ;
                    3'b001: op = OP_BNE;
                    3'b100: op = OP_BLT;
                    3'b101: op = OP_BGE;
                    3'b110: op = OP_BLTU;
                    3'b111: op = OP_BGEU;
                    default: op = OP_NONE;
                endcase
            end
            OPC_JAL: begin
                fmt = FMT_J; cls_wr = 1'b1; cls_jp = 1'b1; op = OP_JAL;
            end
            OPC_JALR: begin
                fmt = FMT_I; cls_wr = 1'b1; cls_jp = 1'b1;
                op = (f3 == 3'b000) ? OP_JALR : OP_NONE;
            end
            default: begin
                op = OP_NONE;
            end
        endcase
    end

    // Purpose: derive the control set, cleared for rejected words.
    always_comb begin
        not_impl   = (op == OP_NONE);
        ctl        = '0;
        if (!not_impl) begin
            ctl.wr_rd  = cls_wr && (rd != '0);
            ctl.mem_rd = cls_ld;
            ctl.mem_wr = cls_st;
            ctl.size   = (cls_ld || cls_st) ? f3[SIZE_W-1:0] : '0;
            ctl.uns    = cls_ld && f3[2];
            ctl.branch = cls_br;
            ctl.jump   = cls_jp;
        end
    end
endmodule

// File: rtl/rvd_decoder.sv
// Top of the reduced decoder: field slicing, operation lookup, immediates.
// Purely combinational; assumes the word is stable while outputs are used.
module rvd_decoder
    import rvd_pkg::*;
(
    input  logic [31:0] instr_i,
    output logic [4:0]  rd_o,
    output logic [4:0]  rs1_o,
    output logic [4:0]  rs2_o,
    output logic [5:0]  op_o,
    output logic [31:0] imm_o,
    output logic        reg_wr_o,
    output logic        mem_rd_o,
    output logic        mem_wr_o,
    output logic [1:0]  mem_size_o,
    output logic        load_unsigned_o,
    output logic        branch_o,
    output logic        jump_o,
    output logic        not_impl_o
);
    logic [OPC_W-1:0] opcode;
    logic [F3_W-1:0]  f3;
    logic [F7_W-1:0]  f7;
    op_e              op;
    fmt_e             fmt;
    ctl_t             ctl;

    rvd_field_split #(.W(ILEN)) u_split (
        .instr  (instr_i),
        .opcode (opcode),
        .rd     (rd_o),
        .f3     (f3),
        .rs1    (rs1_o),
        .rs2    (rs2_o),
        .f7     (f7)
    );

    rvd_op_lookup u_lookup (
        .opcode   (opcode),
        .f3       (f3),
        .f7       (f7),
        .rd       (rd_o),
        .op       (op),
        .fmt      (fmt),
        .ctl      (ctl),
        .not_impl (not_impl_o)
    );

    rvd_imm_gen #(.W(ILEN)) u_imm (
        .instr (instr_i),
        .fmt   (fmt),
        .imm   (imm_o)
    );

    // Purpose: flatten the control struct onto plain ports.
    always_comb begin
        op_o            = op;
        reg_wr_o        = ctl.wr_rd;
        mem_rd_o        = ctl.mem_rd;
        mem_wr_o        = ctl.mem_wr;
        mem_size_o      = ctl.size;
        load_unsigned_o = ctl.uns;
        branch_o        = ctl.branch;
        jump_o          = ctl.jump;
    end
endmodule

// File: rtl/rvd_decoder_chk.sv
// Output invariant checker for the decoder, attached by bind.
// Assumes combinational outputs; checks are immediate, re-run on every change.
module rvd_decoder_chk (
    input logic [31:0] instr_i,
    input logic [4:0]  rd_o,
    input logic [5:0]  op_o,
    input logic [31:0] imm_o,
    input logic        reg_wr_o,
    input logic        mem_rd_o,
    input logic        mem_wr_o,
    input logic [1:0]  mem_size_o,
    input logic        load_unsigned_o,
    input logic        branch_o,
    input logic        jump_o,
    input logic        not_impl_o
);
    // Purpose: evaluate every invariant whenever the outputs move.
    always_comb begin
        AST_REJECT_QUIET: assert (!not_impl_o || (op_o == 6'd0 && !reg_wr_o && !mem_rd_o && !mem_wr_o && !branch_o && !jump_o && !load_unsigned_o)) else $error("rejected word left a control flag set"); // R11
        AST_OP_IN_RANGE: assert (not_impl_o || (op_o >= 6'd1 && op_o <= 6'd33)) else $error("accepted word with out-of-range op"); // R2
        AST_RD0_NO_WRITE: assert (rd_o != 5'd0 || !reg_wr_o) else $error("write flagged for rd 0"); // R10
        AST_MEM_EXCLUSIVE: assert (!(mem_rd_o && mem_wr_o)) else $error("load and store flagged together"); // R8
        AST_SIZE_IDLE: assert (mem_rd_o || mem_wr_o || mem_size_o == 2'd0) else $error("size set without access"); // R8
        AST_BRANCH_EVEN: assert (!branch_o || !imm_o[0]) else $error("odd branch offset"); // R5
        AST_JAL_EVEN: assert (op_o != 6'd32 || !imm_o[0]) else $error("odd jump offset"); // R6
        AST_LUI_LOW_ZERO: assert (op_o != 6'd25 || imm_o[11:0] == 12'd0) else $error("upper immediate has low bits"); // R4
    end
endmodule

bind rvd_decoder rvd_decoder_chk chk_i (
    .instr_i         (instr_i),
    .rd_o            (rd_o),
    .op_o            (op_o),
    .imm_o           (imm_o),
    .reg_wr_o        (reg_wr_o),
    .mem_rd_o        (mem_rd_o),
    .mem_wr_o        (mem_wr_o),
    .mem_size_o      (mem_size_o),
    .load_unsigned_o (load_unsigned_o),
    .branch_o        (branch_o),
    .jump_o          (jump_o),
    .not_impl_o      (not_impl_o)
);

// File: tb/rvd_decoder_tb_top.sv
// Sweep bench for the decoder: every major opcode x func3 x several func7
// values x field patterns, then pseudo-random words, all against a table model.
module rvd_decoder_tb_top;
    logic        clk;
    logic [31:0] instr;
    logic [4:0]  rd, rs1, rs2;
    logic [5:0]  op;
    logic [31:0] imm;
    logic        reg_wr, mem_rd, mem_wr, ld_uns, br, jp, ni;
    logic [1:0]  msize;

    int n_chk  = 0;
    int n_fail = 0;
    bit done   = 0;

    int t_opc [1:33];
    int t_f3  [1:33];
    int t_f7  [1:33];

    initial clk = 1'b0;
    always #5 clk = ~clk;

    rvd_decoder dut_i (
        .instr_i (instr), .rd_o (rd), .rs1_o (rs1), .rs2_o (rs2), .op_o (op),
        .imm_o (imm), .reg_wr_o (reg_wr), .mem_rd_o (mem_rd), .mem_wr_o (mem_wr),
        .mem_size_o (msize), .load_unsigned_o (ld_uns), .branch_o (br),
        .jump_o (jp), .not_impl_o (ni)
    );

    task automatic ent(input int c, input int o, input int f3v, input int f7v);
        t_opc[c] = o; t_f3[c] = f3v; t_f7[c] = f7v;
    endtask

    task automatic check(input string tag, input logic [31:0] act,
                         input logic [31:0] exp, input logic [31:0] w);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s word=%08h actual=%08h expected=%08h", tag, w, act, exp);
        end
    endtask

    function automatic int ref_op(input logic [31:0] w);
        int o  = int'(w[6:0]);
        int f3 = int'(w[14:12]);
        int f7 = int'(w[31:25]);
        for (int c = 1; c <= 33; c++)
            if (t_opc[c] == o && (t_f3[c] < 0 || t_f3[c] == f3) &&
                (t_f7[c] < 0 || t_f7[c] == f7))
                return c;
        return 0;
    endfunction

    function automatic logic [31:0] ref_imm(input logic [31:0] w);
        longint u = longint'(w);
        longint v;
        case (int'(w[6:0]))
            'h13, 'h03, 'h67: begin
                v = (u >> 20) & 'hFFF;
                if (v >= 2048) v = v - 4096;
            end
            'h23: begin
                v = (((u >> 25) & 'h7F) << 5) | ((u >> 7) & 'h1F);
                if (v >= 2048) v = v - 4096;
            end
            'h63: begin
                v = (((u >> 31) & 1) << 12) | (((u >> 7) & 1) << 11) |
                    (((u >> 25) & 'h3F) << 5) | (((u >> 8) & 'hF) << 1);
                if (v >= 4096) v = v - 8192;
            end
            'h37: v = u & 'hFFFFF000;
            'h6F: begin
                v = (((u >> 31) & 1) << 20) | (((u >> 21) & 'h3FF) << 1) |
                    (((u >> 20) & 1) << 11) | (((u >> 12) & 'hFF) << 12);
                if (v >= 1048576) v = v - 2097152;
            end
            default: v = 0;
        endcase
        return v[31:0];
    endfunction

    task automatic apply(input logic [31:0] w);
        int    c, f3, rdv;
        string tg, it, ft;
        bit    wr, ld, st;
        @(negedge clk);
        instr = w;
        #2;
        c   = ref_op(w);
        f3  = int'(w[14:12]);
        rdv = int'(w[11:7]);
        check("R1 rd",  {27'd0, rd},  {27'd0, w[11:7]},  w);
        check("R1 rs1", {27'd0, rs1}, {27'd0, w[19:15]}, w);
        check("R1 rs2", {27'd0, rs2}, {27'd0, w[24:20]}, w);
        tg = (c == 0) ? "R3" : "R2";
        check({tg, " op"}, {26'd0, op}, c, w);
        check({tg, " not_impl"}, {31'd0, ni}, {31'd0, c == 0}, w);
        case (int'(w[6:0]))
            'h63: it = "R5 imm";
            'h6F: it = "R6 imm";
            'h13, 'h03, 'h67, 'h23, 'h37: it = "R4 imm";
            default: it = "R7 imm";
        endcase
        check(it, imm, ref_imm(w), w);
        wr = (c >= 1 && c <= 21) || c == 25 || c == 32 || c == 33;
        ld = (c >= 17 && c <= 21);
        st = (c >= 22 && c <= 24);
        ft = (c == 0) ? "R11" : "";
        check({ft, " R10 reg_wr"}, {31'd0, reg_wr}, {31'd0, wr && rdv != 0}, w);
        check({ft, " R8 mem_rd"}, {31'd0, mem_rd}, {31'd0, ld}, w);
        check({ft, " R8 mem_wr"}, {31'd0, mem_wr}, {31'd0, st}, w);
        check({ft, " R8 size"}, {30'd0, msize}, (ld || st) ? (f3 & 3) : 0, w);
        check({ft, " R8 unsigned"}, {31'd0, ld_uns}, ld ? ((f3 >> 2) & 1) : 0, w);
        check({ft, " R9 branch"}, {31'd0, br}, {31'd0, c >= 26 && c <= 31}, w);
        check({ft, " R9 jump"}, {31'd0, jp}, {31'd0, c == 32 || c == 33}, w);
    endtask

    // Watchdog: a hung run counts as a failure and still reports.
    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            n_fail++;
            $display("FAIL watchdog: run did not complete (all requirements)");
            $display("  End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
            $finish;
        end
    end

    initial begin
        logic [31:0] lf;
        int f7s [5] = '{'h00, 'h20, 'h01, 'h40, 'h7F};
        int prd [3] = '{0, 31, 21};
        int pr1 [3] = '{0, 31, 10};
        int pr2 [3] = '{0, 31, 5};
        // Reference table of accepted encodings (R2): code, opcode, func3, func7.
        ent(1, 'h33, 0, 'h00); ent(2, 'h33, 0, 'h20); ent(3, 'h33, 4, 'h00);
        ent(4, 'h33, 6, 'h00); ent(5, 'h33, 7, 'h00); ent(6, 'h33, 1, 'h00);
        ent(7, 'h33, 5, 'h00); ent(8, 'h33, 5, 'h20); ent(9, 'h33, 2, 'h00);
        ent(10, 'h33, 3, 'h00);
        ent(11, 'h13, 0, -1); ent(12, 'h13, 4, -1); ent(13, 'h13, 6, -1);
        ent(14, 'h13, 7, -1); ent(15, 'h13, 2, -1); ent(16, 'h13, 3, -1);
        ent(17, 'h03, 0, -1); ent(18, 'h03, 1, -1); ent(19, 'h03, 2, -1);
        ent(20, 'h03, 4, -1); ent(21, 'h03, 5, -1);
        ent(22, 'h23, 0, -1); ent(23, 'h23, 1, -1); ent(24, 'h23, 2, -1);
        ent(25, 'h37, -1, -1);
        ent(26, 'h63, 0, -1); ent(27, 'h63, 1, -1); ent(28, 'h63, 4, -1);
        ent(29, 'h63, 5, -1); ent(30, 'h63, 6, -1); ent(31, 'h63, 7, -1);
        ent(32, 'h6F, -1, -1); ent(33, 'h67, 0, -1);

        // Reset-state equivalent: all-zero word is rejected with quiet flags (R3, R11).
        instr = 32'd0;
        apply(32'h0000_0000);
        // Fully-set word must be rejected (R3).
        apply(32'hFFFF_FFFF);
        // Hand-picked words: addi, jal, store at -2048, negative branch (R4, R5, R6).
        apply(32'h7FF0_0113);
        apply(32'h0040_00EF);
        apply(32'h80E7_8023);
        apply(32'hFE00_0EE3);
        apply(32'h0000_17B7);
        apply(32'h0000_8067);

        // Sweep: major opcode x func3 x func7 x field patterns (R1..R11).
        for (int o = 0; o < 128; o++)
            for (int f = 0; f < 8; f++)
                for (int k = 0; k < 5; k++)
                    for (int p = 0; p < 3; p++)
                        apply({f7s[k][6:0], pr2[p][4:0], pr1[p][4:0], f[2:0],
                               prd[p][4:0], o[6:0]});

        // Pseudo-random words steered onto accepted opcodes for immediate variety.
        lf = 32'h1D87_2B41;
        for (int i = 0; i < 3000; i++) begin
            lf = lf ^ (lf << 13);
            lf = lf ^ (lf >> 17);
            lf = lf ^ (lf << 5);
            case (i % 8)
                0: apply({lf[31:7], 7'h13});
                1: apply({lf[31:7], 7'h23});
                2: apply({lf[31:7], 7'h63});
                3: apply({lf[31:7], 7'h6F});
                4: apply({lf[31:7], 7'h37});
                5: apply({lf[31:7], 7'h03});
                6: apply({lf[31:15], 3'b000, lf[11:7], 7'h67});
                default: apply(lf);
            endcase
        end

        done = 1;
        $display("  End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end
endmodule